// File: doc/BRIEF.md
# Half-Bridge Dead-Time Controller

This block turns logic-level switching commands into two gate enables for a half bridge: one for the high-side switch and one for the low-side switch. It runs on a single clock. The analog drive, the isolation and the supply monitors sit outside it, and their results reach it as plain digital flags. A two-bit mode input chooses how the commands are read. In the two-input protected mode, each command drives its own output. In the single-input mode, one PWM command drives both outputs in complement. In the pass-through mode, there is no protection at all.

In the two protected modes, the controller never lets both outputs be high together. An output may only start its turn-on delay once the opposite output has actually gone low. It then waits a programmable dead time before it rises. Turn-off edges pass with no delay. The dead-time setting counts in units of about 5 ns, and the block converts it to clock cycles. Any of the following forces both outputs low: the disable input, any of the three undervoltage flags, or an internal over-temperature state. That state is derived with hysteresis from a digital temperature code.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with both commands low, both gate outputs are low.
- R2: In mode 2'b00 (the value 2'b11 is treated the same way), the high-side output follows cmd_a_i and the low-side output follows cmd_b_i, each after its dead time. When both commands are high, both outputs go low.
- R3: In mode 2'b01, the high-side output follows cmd_a_i and the low-side output follows its complement. cmd_b_i is ignored. Each turn-on still waits for the opposite output to fall and then for the dead time.
- R4: The dead time is N = ceil(dt_set_i x 5 / 8) clock cycles, with a minimum of 1. An output rises on the Nth edge after the first edge that sees its request present and the opposite output low. When the opposite output is already low, this is N+1 edges after the request is applied. When the opposite output must first fall, it is N+2 edges after.
- R5: A withdrawn request drives that output low on the first clock edge, with no dead-time delay.
- R6: If a request is withdrawn before its dead time expires, the output stays low. A later request waits a full fresh dead time.
- R7: A high disable_i drives both outputs low on the next edge. This also holds on the very edge where a dead time would have expired. After release, the outputs resume with a full dead time.
- R8: Any one of uv_in_i, uv_hs_i or uv_ls_i drives both outputs low on the next edge. When the flag clears, the outputs resume following the current commands after a full dead time.
- R9: A temperature code of 155 or more forces both outputs low by the second edge. The outputs stay low until the code drops below 125. A code between these two values keeps the current state. After release, the output rises N+2 edges after the cool code is applied.
- R10: In mode 2'b10, the outputs copy cmd_a_i and cmd_b_i one edge later, with no dead time, and both outputs may be high at once. Disable and the other faults still force the outputs low.
- R11: The dead-time setting is captured only while both outputs are low. A change made during a running count does not alter that count.
- R12: In modes 2'b00, 2'b01 and 2'b11, both outputs are never high together. This holds during hand-over from one output to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00/11 two-input protected, 01 single PWM input, 10 pass-through |
| cmd_a_i | input | 1 | High-side command, or the PWM input in mode 01 |
| cmd_b_i | input | 1 | Low-side command (ignored in mode 01) |
| disable_i | input | 1 | Forces both outputs low while high |
| uv_in_i | input | 1 | Input-side undervoltage flag |
| uv_hs_i | input | 1 | High-side supply undervoltage flag |
| uv_ls_i | input | 1 | Low-side supply undervoltage flag |
| temp_code_i | input | TEMP_W | Temperature code, one count per degree |
| dt_set_i | input | SET_W | Dead-time setting, about 5 ns per unit |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |

## Verification
A fault gate and a dead-time expiry can land on the same clock edge. The output must then stay low rather than flash high for one cycle. The bench provokes this by raising a request and counting exactly N edges. It then asserts disable so that the following edge, the one on which the count would complete, is the edge that sees the fault. It checks that the high-side output is low on that edge and stays low afterwards. On release, it checks that a full fresh dead time is served.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    HB_DUAL     = 2'b00,
    HB_PWM      = 2'b01,
    HB_PASS     = 2'b10,
    HB_DUAL_ALT = 2'b11
  } hb_mode_e;
endpackage

// File: rtl/hb_cmd_decode.sv
module hb_cmd_decode (
  input  logic [1:0] mode_i,
  input  logic       cmd_a_i,
  input  logic       cmd_b_i,
  output logic       req_hi_o,
  output logic       req_lo_o,
  output logic       pass_o
);
  hb_pkg::hb_mode_e mode;
  logic both_on;

  assign mode    = hb_pkg::hb_mode_e'(mode_i);
  assign both_on = cmd_a_i & cmd_b_i;

  always_comb begin
    pass_o   = 1'b0;
    req_hi_o = cmd_a_i & ~both_on;
    req_lo_o = cmd_b_i & ~both_on;
    case (mode)
      hb_pkg::HB_PWM: begin
        req_hi_o = cmd_a_i;
        req_lo_o = ~cmd_a_i;
      end
      hb_pkg::HB_PASS: begin
        req_hi_o = cmd_a_i;
        req_lo_o = cmd_b_i;
        pass_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hb_dt_scale.sv
module hb_dt_scale #(
  parameter int SET_W       = 9,
  parameter int NS_PER_UNIT = 5,
  parameter int CLK_NS      = 8,
  parameter int CNT_W       = 9
) (
  input  logic [SET_W-1:0] set_i,
  output logic [CNT_W-1:0] cycles_o
);
  localparam int PROD_W = SET_W + $clog2(NS_PER_UNIT + CLK_NS + 1) + 1;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quo;

  // ceiling division of the time span by the clock period
  assign prod = PROD_W'(set_i) * PROD_W'(NS_PER_UNIT) + PROD_W'(CLK_NS - 1);
  assign quo  = prod / PROD_W'(CLK_NS);
  assign cycles_o = (quo == '0) ? CNT_W'(1) : quo[CNT_W-1:0];
endmodule

// File: rtl/hb_thermal_hyst.sv
module hb_thermal_hyst #(
  parameter int TEMP_W = 8,
  parameter int HOT    = 155,
  parameter int COOL   = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  logic hot_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     hot_q <= 1'b0;
    else if (hot_q) hot_q <= (temp_i >= TEMP_W'(COOL));
    else            hot_q <= (temp_i >= TEMP_W'(HOT));
  end

  assign hot_o = hot_q;
endmodule

// File: rtl/hb_dt_channel.sv
module hb_dt_channel #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             force_off_i,
  input  logic             pass_i,
  input  logic             other_on_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             gate_o
);
  logic             gate_q;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (force_off_i || !req_i) begin
      // turn-off and cancel take effect at once
      gate_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pass_i) begin
      gate_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (gate_q) begin
      gate_q <= 1'b1;
    end else if (pend_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        gate_q <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end else if (!other_on_i) begin
      pend_q <= 1'b1;
      cnt_q  <= load_i;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int SET_W       = 9,
  parameter int NS_PER_UNIT = 5,
  parameter int CLK_NS      = 8,
  parameter int TEMP_W      = 8,
  parameter int TSD_ON      = 155,
  parameter int TSD_OFF     = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              cmd_a_i,
  input  logic              cmd_b_i,
  input  logic              disable_i,
  input  logic              uv_in_i,
  input  logic              uv_hs_i,
  input  logic              uv_ls_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic [SET_W-1:0]  dt_set_i,
  output logic              gate_hi_o,
  output logic              gate_lo_o
);
  localparam int MAX_CYC = ((2**SET_W - 1) * NS_PER_UNIT + CLK_NS - 1) / CLK_NS;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int NCH     = 2;

  logic             req_hi, req_lo, pass;
  logic             hot;
  logic             force_off;
  logic [CNT_W-1:0] dt_cyc, dt_q;
  logic [NCH-1:0]   req_v, gate_v;

  hb_cmd_decode u_dec (
    .mode_i   (mode_i),
    .cmd_a_i  (cmd_a_i),
    .cmd_b_i  (cmd_b_i),
    .req_hi_o (req_hi),
    .req_lo_o (req_lo),
    .pass_o   (pass)
  );

  hb_thermal_hyst #(.TEMP_W(TEMP_W), .HOT(TSD_ON), .COOL(TSD_OFF)) u_therm (
    .clk    (clk),
    .rst_n  (rst_n),
    .temp_i (temp_code_i),
    .hot_o  (hot)
  );

  hb_dt_scale #(.SET_W(SET_W), .NS_PER_UNIT(NS_PER_UNIT), .CLK_NS(CLK_NS),
                .CNT_W(CNT_W)) u_scale (
    .set_i    (dt_set_i),
    .cycles_o (dt_cyc)
  );

  assign force_off = disable_i | uv_in_i | uv_hs_i | uv_ls_i | hot;

  // setting is captured only while the bridge is fully off
  always_ff @(posedge clk) begin
    if (!rst_n)                  dt_q <= CNT_W'(1);
    else if (gate_v == '0)       dt_q <= dt_cyc;
  end

  assign req_v = {req_lo, req_hi};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hb_dt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_v[g]),
      .force_off_i (force_off),
      .pass_i      (pass),
      .other_on_i  (gate_v[NCH-1-g]),
      .load_i      (dt_q),
      .gate_o      (gate_v[g])
    );
  end

  assign gate_hi_o = gate_v[0];
  assign gate_lo_o = gate_v[1];
endmodule

// File: rtl/hb_deadtime_ctrl_chk.sv
module hb_deadtime_ctrl_chk #(
  parameter int TEMP_W = 8,
  parameter int HOT    = 155,
  parameter int COOL   = 125
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              cmd_a_i,
  input logic              cmd_b_i,
  input logic              disable_i,
  input logic              uv_in_i,
  input logic              uv_hs_i,
  input logic              uv_ls_i,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic              gate_hi_o,
  input logic              gate_lo_o
);
  logic prev_pass;
  logic is_dual;

  assign is_dual = (mode_i == 2'b00) || (mode_i == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_pass <= 1'b1;
    else        prev_pass <= (mode_i == 2'b10);
  end

  p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_pass |-> !(gate_hi_o && gate_lo_o));

  p_gap_before_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_pass && $rose(gate_hi_o)) |-> $past(!gate_lo_o));

  p_fast_off_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual && !cmd_a_i) |=> !gate_hi_o);

  p_fast_off_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dual && !cmd_b_i) |=> !gate_lo_o);

  p_pwm_off_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && cmd_a_i) |=> !gate_lo_o);

  p_disable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> (!gate_hi_o && !gate_lo_o));

  p_uv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_in_i || uv_hs_i || uv_ls_i) |=> (!gate_hi_o && !gate_lo_o));

  p_hot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code_i >= TEMP_W'(HOT)) |-> ##2 (!gate_hi_o && !gate_lo_o));

  p_pass_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !disable_i && !uv_in_i && !uv_hs_i && !uv_ls_i &&
     ($past(temp_code_i) < TEMP_W'(COOL)))
    |=> (gate_hi_o == $past(cmd_a_i)) && (gate_lo_o == $past(cmd_b_i)));
endmodule

bind hb_deadtime_ctrl hb_deadtime_ctrl_chk #(
  .TEMP_W (TEMP_W),
  .HOT    (TSD_ON),
  .COOL   (TSD_OFF)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .cmd_a_i     (cmd_a_i),
  .cmd_b_i     (cmd_b_i),
  .disable_i   (disable_i),
  .uv_in_i     (uv_in_i),
  .uv_hs_i     (uv_hs_i),
  .uv_ls_i     (uv_ls_i),
  .temp_code_i (temp_code_i),
  .gate_hi_o   (gate_hi_o),
  .gate_lo_o   (gate_lo_o)
);

// File: tb/hb_deadtime_ctrl_tb.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       cmd_a, cmd_b, dis, uv_in, uv_hs, uv_ls;
  logic [7:0] temp;
  logic [8:0] dt_set;
  logic       hi, lo;

  int n_chk = 0;
  int n_err = 0;
  int overlap_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_deadtime_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmd_a_i(cmd_a), .cmd_b_i(cmd_b),
    .disable_i(dis), .uv_in_i(uv_in), .uv_hs_i(uv_hs), .uv_ls_i(uv_ls),
    .temp_code_i(temp), .dt_set_i(dt_set), .gate_hi_o(hi), .gate_lo_o(lo)
  );

  // [5:4] mode, [3] cmd_a, [2] cmd_b, [1] expected hi, [0] expected lo
  localparam logic [5:0] VEC [10] = '{
    6'b00_0_0_0_0, 6'b00_1_0_1_0, 6'b00_0_1_0_1, 6'b00_1_1_0_0,
    6'b01_1_1_1_0, 6'b01_0_1_0_1, 6'b10_1_1_1_1, 6'b10_0_1_0_1,
    6'b10_1_0_1_0, 6'b11_1_1_0_0
  };
  localparam int SETS [5] = '{10, 40, 500, 1, 0};
  localparam int EXPS [5] = '{8, 26, 314, 2, 2};

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rise_time(input bit want_lo, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (mode != 2'b10 && hi && lo) overlap_bad++;
      if ((want_lo ? lo : hi) === 1'b1) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk); cmd_a = 1'b0; cmd_b = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_dt(input int v);
    @(negedge clk); dt_set = 9'(v);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; mode = 2'b00; cmd_a = 1'b0; cmd_b = 1'b0; dis = 1'b0;
    uv_in = 1'b0; uv_hs = 1'b0; uv_ls = 1'b0; temp = 8'd25; dt_set = 9'd10;
    repeat (3) @(posedge clk); #1;
    check("R1 hi in reset", hi, 0);
    check("R1 lo in reset", lo, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 hi after reset", hi, 0);
    check("R1 lo after reset", lo, 0);

    // steady-state table
    for (int i = 0; i < 10; i++) begin
      string tag;
      @(negedge clk);
      mode = VEC[i][5:4]; cmd_a = VEC[i][3]; cmd_b = VEC[i][2];
      repeat (30) @(negedge clk);
      tag = (mode == 2'b01) ? "R3" : (mode == 2'b10) ? "R10" : "R2";
      check($sformatf("%s vec%0d hi", tag, i), hi, VEC[i][1]);
      check($sformatf("%s vec%0d lo", tag, i), lo, VEC[i][0]);
    end

    // dead-time length and immediate turn-off
    mode = 2'b00;
    for (int k = 0; k < 5; k++) begin
      idle(); set_dt(SETS[k]);
      @(negedge clk); cmd_a = 1'b1;
      rise_time(1'b0, 400, n);
      check($sformatf("R4 rise set=%0d", SETS[k]), n, EXPS[k]);
      @(negedge clk); cmd_a = 1'b0;
      @(posedge clk); #1;
      check("R5 fall on first edge", hi, 0);
    end

    // single-input hand-over
    idle(); set_dt(10);
    @(negedge clk); mode = 2'b01; cmd_a = 1'b1;
    repeat (20) @(negedge clk);
    cmd_a = 1'b0;
    rise_time(1'b1, 50, n);
    check("R3 lo after pwm fall", n, 9);
    @(negedge clk); cmd_a = 1'b1;
    rise_time(1'b0, 50, n);
    check("R3 hi after pwm rise", n, 9);

    // two-input hand-over
    @(negedge clk); mode = 2'b00; cmd_a = 1'b1; cmd_b = 1'b0;
    repeat (20) @(negedge clk);
    cmd_a = 1'b0; cmd_b = 1'b1;
    rise_time(1'b1, 50, n);
    check("R2 lo after hand-over", n, 9);
    check("R12 no overlap seen", overlap_bad, 0);

    // cancel
    idle();
    @(negedge clk); cmd_a = 1'b1;
    repeat (3) @(negedge clk);
    cmd_a = 1'b0;
    repeat (20) @(negedge clk);
    check("R6 cancelled stays low", hi, 0);
    cmd_a = 1'b1;
    rise_time(1'b0, 50, n);
    check("R6 fresh dead time", n, 8);

    // setting change during a count
    idle(); set_dt(40);
    @(negedge clk); cmd_a = 1'b1;
    n = -1;
    for (int i = 1; i <= 100; i++) begin
      @(posedge clk); #1;
      if (i == 5) dt_set = 9'd10;
      if (hi === 1'b1) begin n = i; break; end
    end
    check("R11 count not shortened", n, 26);
    idle(); set_dt(10);

    // disable
    @(negedge clk); cmd_a = 1'b1;
    repeat (20) @(negedge clk);
    dis = 1'b1;
    @(posedge clk); #1;
    check("R7 disable hi low", hi, 0);
    repeat (10) @(negedge clk);
    check("R7 held low hi", hi, 0);
    check("R7 held low lo", lo, 0);
    dis = 1'b0;
    rise_time(1'b0, 50, n);
    check("R7 resume dead time", n, 8);

    // undervoltage flags
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      uv_in = (k == 0); uv_hs = (k == 1); uv_ls = (k == 2);
      @(posedge clk); #1;
      check($sformatf("R8 flag%0d forces low", k), hi, 0);
      @(negedge clk); uv_in = 1'b0; uv_hs = 1'b0; uv_ls = 1'b0;
      rise_time(1'b0, 50, n);
      check($sformatf("R8 flag%0d resume", k), n, 8);
    end

    // thermal hysteresis
    @(negedge clk); temp = 8'd154;
    repeat (5) @(negedge clk);
    check("R9 below trip stays on", hi, 1);
    temp = 8'd155;
    repeat (2) @(posedge clk); #1;
    check("R9 trip forces low", hi, 0);
    @(negedge clk); temp = 8'd140;
    repeat (20) @(negedge clk);
    check("R9 band keeps shutdown", hi, 0);
    temp = 8'd124;
    rise_time(1'b0, 50, n);
    check("R9 release timing", n, 9);

    // fault on the expiry edge
    idle();
    @(negedge clk); cmd_a = 1'b1;
    repeat (7) @(negedge clk);
    dis = 1'b1;
    @(posedge clk); #1;
    check("R7 fault on expiry edge", hi, 0);
    repeat (5) @(negedge clk);
    check("R7 still low after expiry", hi, 0);
    dis = 1'b0;
    rise_time(1'b0, 50, n);
    check("R7 fresh count after clash", n, 8);

    // pass-through
    @(negedge clk); mode = 2'b10; cmd_a = 1'b1; cmd_b = 1'b1;
    @(posedge clk); #1;
    check("R10 hi without dead time", hi, 1);
    check("R10 lo without dead time", lo, 1);
    @(negedge clk); dis = 1'b1;
    @(posedge clk); #1;
    check("R10 disable hi", hi, 0);
    check("R10 disable lo", lo, 0);
    @(negedge clk); dis = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule